// File: doc/BRIEF.md
# DMA Channel Bus Ownership Controller

This block is the control core of one DMA channel. It decides when the channel asks the system arbiter for the bus, how long it keeps the bus once granted, and when it hands the bus back. A configuration bit picks between two policies. In cycle-steal operation the channel gives up the bus after every transfer unit. In burst operation it keeps the bus across units until the transfer count runs out, or until the external request line goes inactive.

Software or a sequencer loads a transfer with a one-cycle `start` pulse. The pulse carries the unit count, the two start addresses, the unit size, the bus policy and the addressing scheme, and all of these are latched at that moment. In dual addressing every unit is a read at the source followed by a write at the destination. In single addressing every unit is one bus cycle with the acknowledge strobe asserted toward the external device. Both pointers advance by the unit size after each unit. Every bus cycle takes one clock.

Top module: `dma_busmode_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `dack`, `rd_stb`, `wr_stb` and `done` are 0 and `bus_addr` is 0.
- R2: Once raised, `bus_req` stays high as long as `bus_gnt` is low. A read or write strobe is only driven in a cycle that follows a cycle with `bus_gnt` high, and never in the first cycle of a request.
- R3: With `dual_addr`=1, each unit is one cycle with `rd_stb`=1 and `bus_addr` equal to the source pointer, followed at once by one cycle with `wr_stb`=1 and `bus_addr` equal to the destination pointer.
- R4: With `dual_addr`=0, each unit is a single cycle with `rd_stb`=1, `dack`=1 and `bus_addr` equal to the source pointer, and `wr_stb` stays 0.
- R5: With `burst_mode`=0, `bus_req` is 0 in the cycle after the last bus cycle of every unit.
- R6: With `burst_mode`=1, if `dreq_n` is low and `bus_gnt` is high during the last bus cycle of a unit and units remain, the next unit's first bus cycle follows directly, with `bus_req` held high.
- R7: With `burst_mode`=1, if `dreq_n` is high during the last bus cycle of a unit, `bus_req` is 0 in the next cycle. A dual-address read is always completed by its write first.
- R8: After each unit both pointers advance by the unit size. `unit_size` code 0 is a byte (+1), code 1 is a word (+2), and codes 2 and 3 are a longword (+4).
- R9: Exactly `xfer_count` units are performed. After the last one, `done` rises in the next cycle with `bus_req` low, and it stays high until the next accepted `start`.
- R10: A `start` with `xfer_count`=0 raises `done` in the next cycle without any request or bus cycle.
- R11: `start` is accepted only while the channel is idle or done. A pulse during a transfer changes neither the remaining unit count nor the addresses nor the mode.
- R12: A request is raised only in the cycle after `dreq_n` is sampled low while the channel waits for a unit. While `dreq_n` stays high, `bus_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that loads a transfer |
| burst_mode | input | 1 | 1 = burst, 0 = cycle-steal (latched at start) |
| dual_addr | input | 1 | 1 = read then write per unit, 0 = one acknowledged cycle per unit |
| unit_size | input | 2 | Transfer unit size code |
| xfer_count | input | CW (8) | Number of units to move |
| src_addr | input | AW (16) | Source start address |
| dst_addr | input | AW (16) | Destination start address |
| dreq_n | input | 1 | External request, active low, level sensed |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| dack | output | 1 | Acknowledge to the external device in single addressing |
| rd_stb | output | 1 | Read bus cycle strobe |
| wr_stb | output | 1 | Write bus cycle strobe |
| bus_addr | output | AW (16) | Address of the current bus cycle |
| done | output | 1 | Transfer complete |

## Verification
The assertions check these rules on every cycle: a request is held until it is granted, no strobe appears without a prior grant, a read is always followed by its write, the acknowledge never comes with a write, the bus is released after each unit in cycle-steal operation and after a unit ending with an inactive request in burst operation, and units run back to back in burst operation while the request stays active. Only the bench scenarios can show the things that depend on the whole transfer. These are the exact unit count, the pointer step for each size code, that a zero count gives an immediate completion, and that a start pulse in mid-transfer is ignored. The bench checks these against a reference model that predicts every strobe and address cycle by cycle.

// File: rtl/dma_bm_pkg.sv
package dma_bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_REQ    = 3'd2,
    ST_READ   = 3'd3,
    ST_WRITE  = 3'd4,
    ST_SINGLE = 3'd5,
    ST_DONE   = 3'd6
  } bm_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

endpackage

// File: rtl/dma_bm_counter.sv
module dma_bm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  input  logic [CW-1:0] count_in,
  output logic          last
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? count_in : (cnt_q - ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == ONE);

endmodule

// File: rtl/dma_bm_addr.sv
module dma_bm_addr
  import dma_bm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [1:0]    size_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q
);

  localparam int NPTR = 2;

  logic [1:0]               size_q;
  logic [AW-1:0]            step;
  logic [NPTR-1:0][AW-1:0]  init_val;
  logic [NPTR-1:0][AW-1:0]  ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_BYTE;
    end else if (load) begin
      size_q <= size_in;
    end
  end

  always_comb begin
    case (size_q)
      SZ_BYTE: step = AW'(1);
      SZ_WORD: step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign init_val[0] = src_in;
  assign init_val[1] = dst_in;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [AW-1:0] nxt;
    logic          en;
    always_comb begin
      en  = load | advance;
      nxt = load ? init_val[i] : (ptr_q[i] + step);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[i] <= '0;
      end else if (en) begin
        ptr_q[i] <= nxt;
      end
    end
  end

  assign src_q = ptr_q[0];
  assign dst_q = ptr_q[1];

endmodule

// File: rtl/dma_bm_fsm.sv
module dma_bm_fsm
  import dma_bm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic burst_in,
  input  logic dual_in,
  input  logic count_zero,
  input  logic last,
  input  logic dreq_n,
  input  logic bus_gnt,
  output logic load,
  output logic unit_end,
  output logic cfg_burst,
  output logic bus_req,
  output logic dack,
  output logic rd_stb,
  output logic wr_stb,
  output logic done
);

  bm_state_e state_q, state_d;
  logic      burst_q, dual_q;
  logic      dreq_act;
  bm_state_e first_st;

  assign dreq_act = ~dreq_n;
  assign load     = start & ((state_q == ST_IDLE) | (state_q == ST_DONE));
  assign first_st = dual_q ? ST_READ : ST_SINGLE;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (load) state_d = count_zero ? ST_DONE : ST_ARMED;
      end
      ST_ARMED: begin
        if (dreq_act) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (bus_gnt) state_d = first_st;
      end
      ST_READ: state_d = ST_WRITE;
      ST_WRITE, ST_SINGLE: begin
        if (last)                      state_d = ST_DONE;
        else if (burst_q && dreq_act)  state_d = bus_gnt ? first_st : ST_REQ;
        else                           state_d = ST_ARMED;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      dual_q  <= 1'b0;
    end else if (load) begin
      burst_q <= burst_in;
      dual_q  <= dual_in;
    end
  end

  always_comb begin
    bus_req  = (state_q == ST_REQ) | (state_q == ST_READ) |
               (state_q == ST_WRITE) | (state_q == ST_SINGLE);
    rd_stb   = (state_q == ST_READ) | (state_q == ST_SINGLE);
    wr_stb   = (state_q == ST_WRITE);
    dack     = (state_q == ST_SINGLE);
    done     = (state_q == ST_DONE);
    unit_end = (state_q == ST_WRITE) | (state_q == ST_SINGLE);
  end

  assign cfg_burst = burst_q;

endmodule

// File: rtl/dma_busmode_ctrl.sv
module dma_busmode_ctrl #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          burst_mode,
  input  logic          dual_addr,
  input  logic [1:0]    unit_size,
  input  logic [CW-1:0] xfer_count,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          dreq_n,
  input  logic          bus_gnt,
  output logic          bus_req,
  output logic          dack,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [AW-1:0] bus_addr,
  output logic          done
);

  logic          load, unit_end, last, cfg_burst;
  logic [AW-1:0] src_q, dst_q;

  dma_bm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst_in   (burst_mode),
    .dual_in    (dual_addr),
    .count_zero (xfer_count == '0),
    .last       (last),
    .dreq_n     (dreq_n),
    .bus_gnt    (bus_gnt),
    .load       (load),
    .unit_end   (unit_end),
    .cfg_burst  (cfg_burst),
    .bus_req    (bus_req),
    .dack       (dack),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .done       (done)
  );

  dma_bm_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dec      (unit_end),
    .count_in (xfer_count),
    .last     (last)
  );

  dma_bm_addr #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (unit_end),
    .size_in (unit_size),
    .src_in  (src_addr),
    .dst_in  (dst_addr),
    .src_q   (src_q),
    .dst_q   (dst_q)
  );

  always_comb begin
    if (wr_stb)      bus_addr = dst_q;
    else if (rd_stb) bus_addr = src_q;
    else             bus_addr = '0;
  end

endmodule

// File: rtl/dma_busmode_chk.sv
module dma_busmode_chk (
  input logic clk,
  input logic rst_n,
  input logic dreq_n,
  input logic bus_gnt,
  input logic bus_req,
  input logic dack,
  input logic rd_stb,
  input logic wr_stb,
  input logic done,
  input logic cfg_burst
);

  logic unit_last;
  assign unit_last = wr_stb | dack;

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  a_r2_strobe_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> $past(bus_gnt));

  a_r2_no_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !(rd_stb || wr_stb));

  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !dack) |=> (wr_stb && !rd_stb));

  a_r3_write_has_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(rd_stb && !dack));

  a_r4_ack_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (rd_stb && !wr_stb));

  a_r5_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_last && !cfg_burst) |=> !bus_req);

  a_r6_burst_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_last && cfg_burst && !dreq_n && bus_gnt) |=> (done || (rd_stb && bus_req)));

  a_r7_burst_release: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_last && cfg_burst && dreq_n) |=> !bus_req);

  a_r9_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  a_r12_req_needs_dreq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(!dreq_n));

endmodule

bind dma_busmode_ctrl dma_busmode_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dreq_n    (dreq_n),
  .bus_gnt   (bus_gnt),
  .bus_req   (bus_req),
  .dack      (dack),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .done      (done),
  .cfg_burst (cfg_burst)
);

// File: tb/dma_busmode_ctrl_tb.sv
module dma_busmode_ctrl_tb;

  logic        clk, rst_n, start, burst_mode, dual_addr, dreq_n, bus_gnt;
  logic [1:0]  unit_size;
  logic [7:0]  xfer_count;
  logic [15:0] src_addr, dst_addr, bus_addr;
  logic        bus_req, dack, rd_stb, wr_stb, done;

  int n_chk = 0, n_fail = 0;
  int gnt_lat = 1, req_age = 0;
  int rd_cnt = 0, wr_cnt = 0, ack_cnt = 0, rise_cnt = 0;
  int last_rd_addr = 0;
  bit prev_req = 0, finished = 0, cmp_on = 0;

  // behavioural model state
  int m_ph, m_cnt, m_src, m_dst, m_inc;
  bit m_burst, m_dual;

  initial clk = 0;
  always #4 clk = ~clk;

  dma_busmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_mode(burst_mode),
    .dual_addr(dual_addr), .unit_size(unit_size), .xfer_count(xfer_count),
    .src_addr(src_addr), .dst_addr(dst_addr), .dreq_n(dreq_n), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .bus_addr(bus_addr), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 idle,1 wait request,2 requesting,3 read,4 write,5 acked cycle,6 finished
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_src = 0; m_dst = 0; m_inc = 1; m_burst = 0; m_dual = 0;
    end else begin
      case (m_ph)
        0, 6: if (start) begin
          m_burst = burst_mode; m_dual = dual_addr;
          m_inc = (unit_size == 0) ? 1 : (unit_size == 1) ? 2 : 4;
          m_src = src_addr; m_dst = dst_addr; m_cnt = xfer_count;
          m_ph = (xfer_count == 0) ? 6 : 1;
        end
        1: if (!dreq_n) m_ph = 2;
        2: if (bus_gnt) m_ph = m_dual ? 3 : 5;
        3: m_ph = 4;
        4, 5: begin
          m_cnt--; m_src += m_inc; m_dst += m_inc;
          if (m_cnt == 0) m_ph = 6;
          else if (m_burst && !dreq_n) m_ph = bus_gnt ? (m_dual ? 3 : 5) : 2;
          else m_ph = 1;
        end
        default: m_ph = 0;
      endcase
    end
  end

  // per-cycle comparison, monitor and arbiter, all away from the rising edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      int e_addr;
      e_addr = (m_ph == 3 || m_ph == 5) ? (m_src & 16'hFFFF) : (m_ph == 4) ? (m_dst & 16'hFFFF) : 0;
      check(bus_req == (m_ph >= 2 && m_ph <= 5), "R2 bus_req", bus_req, (m_ph >= 2 && m_ph <= 5));
      check(rd_stb == (m_ph == 3 || m_ph == 5), "R3 rd_stb", rd_stb, (m_ph == 3 || m_ph == 5));
      check(wr_stb == (m_ph == 4), "R3 wr_stb", wr_stb, (m_ph == 4));
      check(dack == (m_ph == 5), "R4 dack", dack, (m_ph == 5));
      check(int'(bus_addr) == e_addr, "R8 bus_addr", bus_addr, e_addr);
      check(done == (m_ph == 6), "R9 done", done, (m_ph == 6));
    end
    if (rd_stb) begin rd_cnt++; last_rd_addr = bus_addr; end
    if (wr_stb) wr_cnt++;
    if (dack) ack_cnt++;
    if (bus_req && !prev_req) rise_cnt++;
    prev_req = bus_req;
    if (bus_req) req_age++; else req_age = 0;
    bus_gnt = bus_req && (req_age > gnt_lat);
  end

  task automatic launch(input int cnt, input int s, input int d, input bit b, input bit du, input int sz);
    @(negedge clk);
    start = 1; xfer_count = 8'(cnt); src_addr = 16'(s); dst_addr = 16'(d);
    burst_mode = b; dual_addr = du; unit_size = 2'(sz);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req);
    int k;
    for (k = 0; k < 2000 && !done; k++) @(negedge clk);
    check(done == 1, req, done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r0, w0, a0, q0;
    rst_n = 0; start = 0; burst_mode = 0; dual_addr = 0; unit_size = 0;
    xfer_count = 0; src_addr = 0; dst_addr = 0; dreq_n = 1; bus_gnt = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check({bus_req, dack, rd_stb, wr_stb, done} == 5'b0, "R1 strobes in reset", {bus_req, dack, rd_stb, wr_stb, done}, 0);
    check(bus_addr == 0, "R1 address in reset", bus_addr, 0);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);

    // R5/R3: dual, cycle-steal, bytes, 3 units, grant latency 2
    gnt_lat = 2; dreq_n = 0;
    r0 = rd_cnt; w0 = wr_cnt; q0 = rise_cnt;
    launch(3, 'h100, 'h200, 0, 1, 0);
    wait_done("R9 done after steal transfer");
    check(wr_cnt - w0 == 3, "R3 writes in dual steal", wr_cnt - w0, 3);
    check(rd_cnt - r0 == 3, "R3 reads in dual steal", rd_cnt - r0, 3);
    check(rise_cnt - q0 == 3, "R5 one request per unit", rise_cnt - q0, 3);
    check(last_rd_addr == 'h102, "R8 byte step", last_rd_addr, 'h102);

    // R6/R11: dual burst, words, 4 units; start pulse in mid-transfer ignored
    gnt_lat = 1; q0 = rise_cnt; w0 = wr_cnt;
    launch(4, 'h300, 'h400, 1, 1, 1);
    repeat (3) @(negedge clk);
    launch(9, 'h10, 'h20, 0, 0, 2);
    wait_done("R9 done after burst");
    check(rise_cnt - q0 == 1, "R6 bus held across burst", rise_cnt - q0, 1);
    check(wr_cnt - w0 == 4, "R11 count kept despite start", wr_cnt - w0, 4);
    check(last_rd_addr == 'h306, "R8 word step", last_rd_addr, 'h306);

    // R7/R4: single burst, longwords, 5 units, request dropped mid-way
    q0 = rise_cnt; w0 = wr_cnt; a0 = ack_cnt;
    launch(5, 'h500, 'h600, 1, 0, 2);
    repeat (4) @(negedge clk);
    dreq_n = 1;
    repeat (4) @(negedge clk);
    dreq_n = 0;
    wait_done("R9 done after interrupted burst");
    check(rise_cnt - q0 >= 2, "R7 release on inactive request", rise_cnt - q0, 2);
    check(ack_cnt - a0 == 5, "R4 acked units", ack_cnt - a0, 5);
    check(wr_cnt - w0 == 0, "R4 no writes in single mode", wr_cnt - w0, 0);
    check(last_rd_addr == 'h510, "R8 longword step", last_rd_addr, 'h510);

    // R10: zero count
    r0 = rd_cnt; q0 = rise_cnt;
    launch(0, 'h700, 'h800, 0, 1, 0);
    check(done == 1, "R10 done at once", done, 1);
    check(rise_cnt - q0 == 0 && rd_cnt - r0 == 0, "R10 no bus activity", rise_cnt - q0, 0);

    // R12/R8: request held inactive, then size code 3 single steal
    dreq_n = 1; q0 = rise_cnt;
    launch(2, 'h40, 'h80, 0, 0, 3);
    repeat (10) @(negedge clk);
    check(rise_cnt - q0 == 0, "R12 no request while dreq_n high", rise_cnt - q0, 0);
    dreq_n = 0;
    wait_done("R9 done after size 3 transfer");
    check(last_rd_addr == 'h44, "R8 size code 3 step", last_rd_addr, 'h44);
    check(rise_cnt - q0 == 2, "R5 release per unit single", rise_cnt - q0, 2);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule